// File: doc/BRIEF.md
# Nested Trap Entry and Return Sequencer

This block sequences trap entry and trap return for a processor that supports nested trap levels. When a trap is requested, it saves the interrupted context into the slot for the current level. That context is the program counter, next program counter, trap type, and a packed state word. The state word holds the condition codes, address-space identifier, processor state and window pointer. The block then forces a privileged processor state, forms the handler vector from the trap base and the trap type, and raises the trap level.

A done or retry strobe unwinds the most recent level. It hands the saved condition codes, address-space identifier and window pointer back to the core, and it reloads the processor state. It also redirects the fetch stream, either to the faulting instruction (retry) or to the one after it (done).

The core owns the program counter, the condition codes, the address-space identifier and the window pointer, and presents them as inputs. This block owns the trap level, the processor state and the per-level save slots. All results appear one clock after the request.

Top module: `trap_seq`

## Requirements
- R1: After reset the trap level is 0, the processor state is 0, and `redir_vld`, `ret_vld` and `err_o` are low.
- R2: An accepted trap writes into slot L, where L is the trap level before the trap. The slot receives `pc_i`, `npc_i`, `trap_type` and a 40-bit state word laid out as ccr[39:32], asi[31:24], zero[23:20], processor state[19:8], cwp[7:0]. While the level is nonzero, `tt_o` shows the trap type held in slot level-1; at level 0 it shows 0.
- R3: After an accepted trap, the processor state is 0x015 (alternate globals bit 0, privileged bit 2, FP enable bit 4). If the reduced-state condition of R5 applies, it is 0x035 instead (bit 5 also set).
- R4: One cycle after an accepted trap, `redir_vld` pulses and `redir_pc` equals `tba_i` with its low 15 bits replaced. Bit 14 is set if the pre-trap level was greater than 1, bits 13:5 carry the trap type, and bits 4:0 are zero. `redir_npc` is `redir_pc` + 4, and `ret_vld` stays low.
- R5: A trap taken below level MAXTL-1 increments the level without setting the reduced-state bit. A trap taken at level MAXTL-1 sets the reduced-state bit and takes the level to MAXTL.
- R6: A trap requested at level MAXTL pulses `err_o` for one cycle. No redirect is issued, and the level, the processor state and the save slots are unchanged.
- R7: Retry at level L>0 redirects to the saved PC of slot L-1, with the saved next-PC as `redir_npc`.
- R8: Done at level L>0 redirects to the saved next-PC of slot L-1, with that value plus 4 as `redir_npc`.
- R9: Done and retry both pulse `ret_vld` together with `redir_vld`. They present the saved ccr, asi and cwp of slot L-1 on `ret_ccr`, `ret_asi` and `ret_cwp`, reload the processor state from that slot, and decrement the level by one.
- R10: Done or retry at level 0 is ignored: no redirect pulses, and the level and processor state stay the same.
- R11: A trap request wins over done and retry in the same cycle, and done wins over retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Trap request strobe |
| trap_type | input | 9 | Trap type of the request |
| done_req | input | 1 | Return to the instruction after the trapped one |
| retry_req | input | 1 | Return to the trapped instruction |
| pc_i | input | AW | Current program counter |
| npc_i | input | AW | Current next program counter |
| ccr_i | input | 8 | Current condition codes |
| asi_i | input | 8 | Current address-space identifier |
| cwp_i | input | 8 | Current window pointer |
| tba_i | input | AW | Trap base; low 15 bits are replaced |
| redir_vld | output | 1 | Fetch redirect pulse |
| redir_pc | output | AW | Redirect program counter |
| redir_npc | output | AW | Redirect next program counter |
| ret_vld | output | 1 | Restore pulse for ccr, asi, cwp |
| ret_ccr | output | 8 | Restored condition codes |
| ret_asi | output | 8 | Restored address-space identifier |
| ret_cwp | output | 8 | Restored window pointer |
| pstate_o | output | 12 | Processor state |
| tl_o | output | TLW | Current trap level |
| tt_o | output | 9 | Trap type of the innermost active level |
| err_o | output | 1 | Trap-at-maximum-level error pulse |

## Verification
The bench builds the block with MAXTL = 4 and AW = 32. The small maximum level lets random streams of traps reach the reduced-state level and the maximum-level error often. The narrow address keeps the vector and saved PCs readable. Directed sequences first climb to the ceiling and unwind to level 0, then test same-cycle conflicts between traps and returns. A random mix of traps, dones and retries follows, compared against a software copy of the level stack.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
   localparam int TT_W = 9;
   localparam int PS_W = 12;
   localparam int PS_AG   = 0;
   localparam int PS_PRIV = 2;
   localparam int PS_PEF  = 4;
   localparam int PS_RED  = 5;
   localparam logic [PS_W-1:0] PS_ENTRY =
      PS_W'((1 << PS_AG) | (1 << PS_PRIV) | (1 << PS_PEF));
   localparam logic [PS_W-1:0] PS_RED_MASK = PS_W'(1 << PS_RED);

   // saved context word, bit positions fixed by the state layout
   typedef struct packed {
      logic [7:0]      ccr;
      logic [7:0]      asi;
      logic [3:0]      rsvd;
      logic [PS_W-1:0] ps;
      logic [7:0]      cwp;
   } tstate_t;

   function automatic tstate_t pack_state(logic [7:0] ccr, logic [7:0] asi,
                                          logic [PS_W-1:0] ps, logic [7:0] cwp);
      tstate_t s;
      s.ccr  = ccr;
      s.asi  = asi;
      s.rsvd = '0;
      s.ps   = ps;
      s.cwp  = cwp;
      return s;
   endfunction
endpackage

// File: rtl/trap_level_ctl.sv
module trap_level_ctl #(
   parameter int MAXTL = 5,
   parameter int TLW   = $clog2(MAXTL + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           inc,
   input  logic           dec,
   output logic [TLW-1:0] tl,
   output logic           at_max,
   output logic           red_entry,
   output logic           nested
);
   localparam logic [TLW-1:0] TL_MAX = TLW'(MAXTL);
   localparam logic [TLW-1:0] TL_RED = TLW'(MAXTL - 1);

   assign at_max    = (tl == TL_MAX);
   assign red_entry = (tl >= TL_RED);
   assign nested    = (tl > TLW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)
         tl <= '0;
      else if (inc && !at_max)
         tl <= tl + TLW'(1);
      else if (dec && tl != '0)
         tl <= tl - TLW'(1);
   end

   // R5
   tl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tl <= TL_MAX);
   // R9
   tl_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !inc && tl != '0) |=> (tl == $past(tl) - TLW'(1)));
endmodule

// File: rtl/trap_stack.sv
module trap_stack
   import trap_seq_pkg::*;
#(
   parameter int MAXTL = 5,
   parameter int AW    = 64,
   parameter int SW    = (MAXTL > 1) ? $clog2(MAXTL) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [SW-1:0]   widx,
   input  logic [AW-1:0]   wpc,
   input  logic [AW-1:0]   wnpc,
   input  tstate_t         wst,
   input  logic [TT_W-1:0] wtt,
   input  logic [SW-1:0]   ridx,
   output logic [AW-1:0]   rpc,
   output logic [AW-1:0]   rnpc,
   output tstate_t         rst,
   output logic [TT_W-1:0] rtt
);
   logic [AW-1:0]   pc_q  [MAXTL];
   logic [AW-1:0]   npc_q [MAXTL];
   tstate_t         st_q  [MAXTL];
   logic [TT_W-1:0] tt_q  [MAXTL];

   for (genvar g = 0; g < MAXTL; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pc_q[g]  <= '0;
            npc_q[g] <= '0;
            st_q[g]  <= '0;
            tt_q[g]  <= '0;
         end else if (we && widx == SW'(g)) begin
            pc_q[g]  <= wpc;
            npc_q[g] <= wnpc;
            st_q[g]  <= wst;
            tt_q[g]  <= wtt;
         end
      end
   end

   assign rpc  = pc_q[ridx];
   assign rnpc = npc_q[ridx];
   assign rst  = st_q[ridx];
   assign rtt  = tt_q[ridx];

   // R2
   slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (int'(widx) < MAXTL));
endmodule

// File: rtl/trap_seq.sv
module trap_seq
   import trap_seq_pkg::*;
#(
   parameter int MAXTL = 5,
   parameter int AW    = 64,
   parameter int TLW   = $clog2(MAXTL + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            trap_req,
   input  logic [8:0]      trap_type,
   input  logic            done_req,
   input  logic            retry_req,
   input  logic [AW-1:0]   pc_i,
   input  logic [AW-1:0]   npc_i,
   input  logic [7:0]      ccr_i,
   input  logic [7:0]      asi_i,
   input  logic [7:0]      cwp_i,
   input  logic [AW-1:0]   tba_i,
   output logic            redir_vld,
   output logic [AW-1:0]   redir_pc,
   output logic [AW-1:0]   redir_npc,
   output logic            ret_vld,
   output logic [7:0]      ret_ccr,
   output logic [7:0]      ret_asi,
   output logic [7:0]      ret_cwp,
   output logic [11:0]     pstate_o,
   output logic [TLW-1:0]  tl_o,
   output logic [8:0]      tt_o,
   output logic            err_o
);
   localparam int SW = (MAXTL > 1) ? $clog2(MAXTL) : 1;
   localparam int VEC_LSB = 15;

   if (MAXTL < 2) begin : g_bad_maxtl
      $error("trap_seq: MAXTL must be at least 2");
   end
   if (AW < VEC_LSB + 1) begin : g_bad_aw
      $error("trap_seq: AW must exceed the vector field");
   end

   logic            at_max, red_entry, nested;
   logic            trap_ok, trap_err, do_done, do_retry, do_ret;
   logic [AW-1:0]   s_pc, s_npc;
   tstate_t         s_st;
   logic [TT_W-1:0] s_tt;
   logic [SW-1:0]   wr_slot, rd_slot;
   logic [AW-1:0]   vec;

   // request decode: trap > done > retry; returns need an active level
   assign trap_ok  = trap_req && !at_max;
   assign trap_err = trap_req && at_max;
   assign do_done  = !trap_req && done_req && (tl_o != '0);
   assign do_retry = !trap_req && !done_req && retry_req && (tl_o != '0);
   assign do_ret   = do_done || do_retry;

   assign wr_slot = SW'(tl_o);
   assign rd_slot = SW'(tl_o - TLW'(1));

   trap_level_ctl #(.MAXTL(MAXTL), .TLW(TLW)) i_lvl (
      .clk(clk), .rst_n(rst_n), .inc(trap_ok), .dec(do_ret),
      .tl(tl_o), .at_max(at_max), .red_entry(red_entry), .nested(nested));

   trap_stack #(.MAXTL(MAXTL), .AW(AW), .SW(SW)) i_stk (
      .clk(clk), .rst_n(rst_n), .we(trap_ok), .widx(wr_slot),
      .wpc(pc_i), .wnpc(npc_i),
      .wst(pack_state(ccr_i, asi_i, pstate_o, cwp_i)), .wtt(trap_type),
      .ridx(rd_slot), .rpc(s_pc), .rnpc(s_npc), .rst(s_st), .rtt(s_tt));

   assign vec  = {tba_i[AW-1:VEC_LSB], nested, trap_type, 5'b0};
   assign tt_o = (tl_o != '0) ? s_tt : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pstate_o  <= '0;
         redir_vld <= 1'b0;
         redir_pc  <= '0;
         redir_npc <= '0;
         ret_vld   <= 1'b0;
         ret_ccr   <= '0;
         ret_asi   <= '0;
         ret_cwp   <= '0;
         err_o     <= 1'b0;
      end else begin
         redir_vld <= trap_ok || do_ret;
         ret_vld   <= do_ret;
         err_o     <= trap_err;
         if (trap_ok) begin
            pstate_o  <= PS_ENTRY | (red_entry ? PS_RED_MASK : '0);
            redir_pc  <= vec;
            redir_npc <= vec + AW'(4);
         end else if (do_ret) begin
            pstate_o  <= s_st.ps;
            ret_ccr   <= s_st.ccr;
            ret_asi   <= s_st.asi;
            ret_cwp   <= s_st.cwp;
            redir_pc  <= do_done ? s_npc : s_pc;
            redir_npc <= do_done ? s_npc + AW'(4) : s_npc;
         end
      end
   end

   // R3
   entry_ps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_ok |=> (pstate_o[PS_PRIV] && pstate_o[PS_AG] && pstate_o[PS_PEF]));
   // R6
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_err |=> (err_o && !redir_vld && $stable(tl_o) && $stable(pstate_o)));
   // R10
   idle_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!trap_req && (done_req || retry_req) && tl_o == '0) |=> !redir_vld);
   // R11
   ret_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(err_o && redir_vld) && (!ret_vld || redir_vld));
endmodule

// File: tb/test_trap_seq.sv
module test_trap_seq;
   localparam int MAXTL = 4;
   localparam int AW    = 32;
   localparam int TLW   = $clog2(MAXTL + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic trap_req = 0, done_req = 0, retry_req = 0;
   logic [8:0] trap_type = '0;
   logic [AW-1:0] pc_i = '0, npc_i = '0, tba_i = '0;
   logic [7:0] ccr_i = '0, asi_i = '0, cwp_i = '0;
   logic redir_vld, ret_vld, err_o;
   logic [AW-1:0] redir_pc, redir_npc;
   logic [7:0] ret_ccr, ret_asi, ret_cwp;
   logic [11:0] pstate_o;
   logic [TLW-1:0] tl_o;
   logic [8:0] tt_o;

   always #5 clk = ~clk;

   trap_seq #(.MAXTL(MAXTL), .AW(AW)) i_trap_seq (
      .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_type(trap_type),
      .done_req(done_req), .retry_req(retry_req), .pc_i(pc_i), .npc_i(npc_i),
      .ccr_i(ccr_i), .asi_i(asi_i), .cwp_i(cwp_i), .tba_i(tba_i),
      .redir_vld(redir_vld), .redir_pc(redir_pc), .redir_npc(redir_npc),
      .ret_vld(ret_vld), .ret_ccr(ret_ccr), .ret_asi(ret_asi), .ret_cwp(ret_cwp),
      .pstate_o(pstate_o), .tl_o(tl_o), .tt_o(tt_o), .err_o(err_o));

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   // reference model
   int m_tl = 0;
   logic [11:0] m_ps = '0;
   logic [AW-1:0] m_pc [MAXTL];
   logic [AW-1:0] m_npc [MAXTL];
   logic [39:0] m_st [MAXTL];
   logic [8:0] m_tt [MAXTL];

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] vec_of(logic [AW-1:0] tba, int lvl, logic [8:0] tt);
      return {tba[AW-1:15], (lvl > 1), tt, 5'b0};
   endfunction

   function automatic logic [11:0] entry_ps(int lvl);
      return (lvl >= MAXTL - 1) ? 12'h035 : 12'h015;
   endfunction

   task automatic check_state(string req);
      chk(req, "tl_o", 64'(tl_o), 64'(m_tl));
      chk(req, "pstate_o", 64'(pstate_o), 64'(m_ps));
      chk("R2", "tt_o", 64'(tt_o), (m_tl > 0) ? 64'(m_tt[m_tl-1]) : 64'd0);
   endtask

   // op: 0 idle, apply the strobes given, compare one edge later
   task automatic apply(bit t, bit d, bit r, logic [8:0] tt);
      bit exp_rv = 0, exp_ret = 0, exp_err = 0;
      logic [AW-1:0] e_pc = '0, e_npc = '0;
      logic [39:0] sw = '0;
      string req;
      @(negedge clk);
      trap_req = t; done_req = d; retry_req = r; trap_type = tt;
      pc_i = $urandom; npc_i = $urandom; ccr_i = 8'($urandom);
      asi_i = 8'($urandom); cwp_i = 8'($urandom); tba_i = $urandom;
      if (t) begin
         if (m_tl == MAXTL) begin
            exp_err = 1; req = "R6";
         end else begin
            req = (d || r) ? "R11" : "R4";
            m_pc[m_tl] = pc_i; m_npc[m_tl] = npc_i; m_tt[m_tl] = tt;
            m_st[m_tl] = {ccr_i, asi_i, 4'h0, m_ps, cwp_i};
            exp_rv = 1;
            e_pc = vec_of(tba_i, m_tl, tt); e_npc = e_pc + 4;
            m_ps = entry_ps(m_tl);
            m_tl++;
         end
      end else if ((d || r) && m_tl > 0) begin
         sw = m_st[m_tl-1];
         exp_rv = 1; exp_ret = 1;
         if (d) begin
            req = r ? "R11" : "R8";
            e_pc = m_npc[m_tl-1]; e_npc = m_npc[m_tl-1] + 4;
         end else begin
            req = "R7";
            e_pc = m_pc[m_tl-1]; e_npc = m_npc[m_tl-1];
         end
         m_ps = sw[19:8];
         m_tl--;
      end else begin
         req = "R10";
      end
      @(posedge clk); #1;
      chk(req, "redir_vld", 64'(redir_vld), 64'(exp_rv));
      chk(req, "err_o", 64'(err_o), 64'(exp_err));
      chk("R9", "ret_vld", 64'(ret_vld), 64'(exp_ret));
      if (exp_rv) begin
         chk(req, "redir_pc", 64'(redir_pc), 64'(e_pc));
         chk(req, "redir_npc", 64'(redir_npc), 64'(e_npc));
      end
      if (exp_ret) begin
         chk("R9", "ret_ccr", 64'(ret_ccr), 64'(sw[39:32]));
         chk("R9", "ret_asi", 64'(ret_asi), 64'(sw[31:24]));
         chk("R9", "ret_cwp", 64'(ret_cwp), 64'(sw[7:0]));
      end
      check_state(t ? ((m_tl >= MAXTL - 1 && !exp_err) ? "R5" : "R3") : req);
      @(negedge clk);
      trap_req = 0; done_req = 0; retry_req = 0;
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int unused = $urandom(32'd2024);
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1", "tl_o", 64'(tl_o), 0);
      chk("R1", "pstate_o", 64'(pstate_o), 0);
      chk("R1", "redir_vld", 64'(redir_vld), 0);
      chk("R1", "ret_vld", 64'(ret_vld), 0);
      chk("R1", "err_o", 64'(err_o), 0);
      @(negedge clk); rst_n = 1;
      // R10 returns at level 0
      apply(0, 1, 0, 9'h0);
      apply(0, 0, 1, 9'h0);
      // R5 climb to the ceiling, then R6 error
      for (int i = 0; i < MAXTL; i++) apply(1, 0, 0, 9'(9'h041 + i));
      apply(1, 0, 0, 9'h1ff);
      // R8 / R7 unwind
      apply(0, 1, 0, 9'h0);
      apply(0, 0, 1, 9'h0);
      apply(0, 1, 0, 9'h0);
      apply(0, 0, 1, 9'h0);
      apply(0, 1, 0, 9'h0);
      // R11 conflicts
      apply(1, 1, 1, 9'h123);
      apply(0, 1, 1, 9'h0);
      // random mix
      for (int i = 0; i < 400; i++) begin
         int sel = $urandom_range(0, 9);
         if (sel < 4)      apply(1, 0, 0, 9'($urandom));
         else if (sel < 6) apply(0, 1, 0, 9'($urandom));
         else if (sel < 8) apply(0, 0, 1, 9'($urandom));
         else              apply(1'($urandom), 1'($urandom), 1'($urandom), 9'($urandom));
      end
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule